// File: doc/BRIEF.md
# Bit-Serial ROM Read Sequencer

This block reads a run of bytes from a bit-serial EEPROM. The EEPROM is reached only through a small control register that holds a serial clock, a data-out bit, a data-in bit and two access-enable bits, one high and one low. A request carries a 16-bit byte offset and a byte count. The sequencer first opens access in two ordered register updates. It then clocks out the read command and the two address bytes, clocks in the requested number of bytes, and closes access again in the mirrored two-step order.

Every register state is held for a programmable number of system clocks, `div + 1`, so that the serial clock can be kept slow enough for the device. Received bytes leave on a valid/ready stream. While `out_valid` is high and `out_ready` is low, the byte and the serial engine are frozen: no serial clock edge is made until the byte is taken. A byte moves on any rising clock edge where both `out_valid` and `out_ready` are high. `out_data` may change only after that transfer.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset the outputs are `acc_hi`=0, `acc_lo`=1, `rom_clk`=0, `busy`=0, `out_valid`=0 and `done`=0.
- R2: Opening access first raises `acc_hi` while `acc_lo` stays 1, and only later clears `acc_lo`. `rom_clk` is high only while `acc_hi`=1 and `acc_lo`=0.
- R3: The first 24 bits shifted out are the command byte 0x03, then offset bits 15..8, then offset bits 7..0, each byte most significant bit first. The device takes each bit on the rise of `rom_clk`. `rom_dout` changes only in a state where the clock is low, and never on the same edge where the clock rises.
- R4: Each input bit is sampled from `rom_din` at the end of a clock-high state. Bits are packed most significant bit first. Byte n of the stream is the ROM content at offset+n.
- R5: Exactly `req_count` bytes are delivered, and the serial clock pulses exactly 24 + 8*count times. A count of zero still sends the command and address and still runs both access handshakes.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high, `out_data` is stable and `rom_clk` does not change.
- R7: Closing access happens after the last byte is accepted. It first sets `acc_lo`, then clears `acc_hi`, which leaves the pins in the reset state.
- R8: `busy` goes high in the cycle after the edge that accepts a request. It stays high until the closing handshake ends. `done` is high for exactly one cycle, the first cycle with `busy` low again.
- R9: A request presented while `busy`=1 has no effect. The transfer in progress keeps its offset and count, and no further transfer starts afterwards.
- R10: While busy, each control-register state (the access bits, clock and data-out) is held for at least `div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, taken on an edge where busy is low |
| req_offset | input | 16 | Byte offset of the first byte to read |
| req_count | input | CNT_W | Number of bytes to read |
| div | input | DIV_W | Extra system clocks each register state is held |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| rom_clk | output | 1 | Serial clock bit of the control register |
| rom_dout | output | 1 | Serial data towards the EEPROM |
| rom_din | input | 1 | Serial data from the EEPROM |
| acc_hi | output | 1 | High access-enable bit |
| acc_lo | output | 1 | Low access-enable bit (1 = access closed) |

## Verification
The bench sweeps the divider, the byte count (zero included) and offsets at both ends of the address range against a behavioural EEPROM. That model moves its output bit on every falling clock. A design that sampled on the wrong phase would therefore return every byte shifted by one bit. A design that flipped the handshake order, or changed data-out on the same edge as a clock rise, shows up in the logged order of control-register changes. Stalling the consumer for several cycles catches an engine that clocks on while a byte is still waiting, and it also catches a byte that changes before it is taken. A second request issued in mid-transfer must leave the header and the byte count untouched.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

  localparam logic [7:0] READ_CMD = 8'h03;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN_HI,
    ST_EN_LO,
    ST_OUT_SET,
    ST_OUT_HI,
    ST_OUT_LO,
    ST_IN_HI,
    ST_IN_LO,
    ST_PUSH,
    ST_DIS_LO,
    ST_DIS_HI
  } seq_state_e;

  typedef struct packed {
    logic acc_hi;
    logic acc_lo;
    logic sclk;
  } pin_ctl_t;

  // Pin image of the control register for each sequencer state.
  function automatic pin_ctl_t pins_for(seq_state_e s);
    pin_ctl_t p;
    case (s)
      ST_IDLE, ST_DIS_HI:   p = '{acc_hi: 1'b0, acc_lo: 1'b1, sclk: 1'b0};
      ST_EN_HI, ST_DIS_LO:  p = '{acc_hi: 1'b1, acc_lo: 1'b1, sclk: 1'b0};
      ST_OUT_HI, ST_IN_HI:  p = '{acc_hi: 1'b1, acc_lo: 1'b0, sclk: 1'b1};
      default:              p = '{acc_hi: 1'b1, acc_lo: 1'b0, sclk: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rom_step_timer.sv
module rom_step_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rom_bit_shifter.sv
module rom_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         bit_done,
  output logic [W-1:0] q,
  output logic         msb_next,
  output logic         last_bit
);
  localparam int BIT_W = $clog2(W);

  logic [W-1:0]     sh_q;
  logic [BIT_W-1:0] bit_q;

  assign q        = sh_q;
  assign last_bit = (bit_q == BIT_W'(W - 1));
  // Value the top bit will hold after this edge.
  assign msb_next = load ? load_val[W-1] : (shift_en ? sh_q[W-2] : sh_q[W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else begin
      if (load)          sh_q <= load_val;
      else if (shift_en) sh_q <= {sh_q[W-2:0], shift_bit};
      if (load)          bit_q <= '0;
      else if (bit_done) bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import rom_seq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              rom_clk,
  output logic              rom_dout,
  input  logic              rom_din,
  output logic              acc_hi,
  output logic              acc_lo
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int HDR_W      = $clog2(ADDR_BYTES + 1);

  seq_state_e        state_q, state_d;
  pin_ctl_t          pins_q;
  logic              dout_q, done_q;
  logic [ADDR_W-1:0] off_q;
  logic [HDR_W-1:0]  hdr_left_q;
  logic [CNT_W-1:0]  rem_q;

  logic       tick;
  logic       sh_load, sh_shift, sh_bit, bit_done;
  logic [7:0] sh_val, sh_q;
  logic       msb_next, last_bit;
  logic       accept, hdr_next, pop, finish;

  rom_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .div     (div),
    .tick    (tick)
  );

  rom_bit_shifter #(.W(8)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_val  (sh_val),
    .shift_en  (sh_shift),
    .shift_bit (sh_bit),
    .bit_done  (bit_done),
    .q         (sh_q),
    .msb_next  (msb_next),
    .last_bit  (last_bit)
  );

  always_comb begin
    state_d  = state_q;
    sh_load  = 1'b0;
    sh_val   = READ_CMD;
    sh_shift = 1'b0;
    sh_bit   = 1'b0;
    bit_done = 1'b0;
    accept   = 1'b0;
    hdr_next = 1'b0;
    pop      = 1'b0;
    finish   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept  = 1'b1;
        sh_load = 1'b1;
        state_d = ST_EN_HI;
      end
      ST_EN_HI:   if (tick) state_d = ST_EN_LO;
      ST_EN_LO:   if (tick) state_d = ST_OUT_SET;
      ST_OUT_SET: if (tick) state_d = ST_OUT_HI;
      ST_OUT_HI:  if (tick) state_d = ST_OUT_LO;
      ST_OUT_LO: if (tick) begin
        bit_done = 1'b1;
        if (!last_bit) begin
          sh_shift = 1'b1;
          state_d  = ST_OUT_SET;
        end else if (hdr_left_q != '0) begin
          sh_load  = 1'b1;
          sh_val   = off_q[ADDR_W-1 -: 8];
          hdr_next = 1'b1;
          state_d  = ST_OUT_SET;
        end else if (rem_q == '0) begin
          state_d = ST_DIS_LO;
        end else begin
          state_d = ST_IN_HI;
        end
      end
      ST_IN_HI: if (tick) begin
        sh_shift = 1'b1;
        sh_bit   = rom_din;
        state_d  = ST_IN_LO;
      end
      ST_IN_LO: if (tick) begin
        bit_done = 1'b1;
        state_d  = last_bit ? ST_PUSH : ST_IN_HI;
      end
      ST_PUSH: if (out_ready) begin
        pop     = 1'b1;
        state_d = (rem_q == CNT_W'(1)) ? ST_DIS_LO : ST_IN_HI;
      end
      ST_DIS_LO: if (tick) state_d = ST_DIS_HI;
      ST_DIS_HI: if (tick) begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pins_q     <= pins_for(ST_IDLE);
      dout_q     <= 1'b0;
      done_q     <= 1'b0;
      off_q      <= '0;
      hdr_left_q <= '0;
      rem_q      <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
      done_q  <= finish;
      if (state_d == ST_OUT_SET && state_q != ST_OUT_SET) dout_q <= msb_next;
      if (accept) begin
        off_q      <= req_offset;
        hdr_left_q <= HDR_W'(ADDR_BYTES);
        rem_q      <= req_count;
      end else begin
        if (hdr_next) begin
          off_q      <= off_q << 8;
          hdr_left_q <= hdr_left_q - 1'b1;
        end
        if (pop) rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign out_valid = (state_q == ST_PUSH);
  assign out_data  = sh_q;
  assign rom_clk   = pins_q.sclk;
  assign rom_dout  = dout_q;
  assign acc_hi    = pins_q.acc_hi;
  assign acc_lo    = pins_q.acc_lo;
endmodule

// File: rtl/rom_reader_checker.sv
module rom_reader_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_hi,
  input logic             acc_lo,
  input logic             rom_clk,
  input logic             rom_dout,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             busy,
  input logic             done,
  input logic [DIV_W-1:0] div
);
  logic [3:0]     ctl_prev;
  logic [DIV_W:0] held;
  logic           ctl_moved;

  assign ctl_moved = ({acc_hi, acc_lo, rom_clk, rom_dout} != ctl_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_prev <= 4'b0100;
      held     <= '0;
    end else begin
      ctl_prev <= {acc_hi, acc_lo, rom_clk, rom_dout};
      if (ctl_moved)        held <= '0;
      else if (held != '1)  held <= held + 1'b1;
    end
  end

  p_clk_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_clk |-> (acc_hi && !acc_lo));
  p_enable_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_hi) |-> acc_lo);
  p_dout_before_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_clk) |-> $stable(rom_dout));
  p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(rom_clk)));
  p_disable_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_hi) |-> acc_lo);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !acc_hi && acc_lo));
  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  p_hold_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_moved && busy && $past(busy)) |-> (held >= {1'b0, div}));
endmodule

bind serial_rom_reader rom_reader_checker #(.DIV_W(DIV_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_hi    (acc_hi),
  .acc_lo    (acc_lo),
  .rom_clk   (rom_clk),
  .rom_dout  (rom_dout),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .busy      (busy),
  .done      (done),
  .div       (div)
);

// File: tb/serial_rom_reader_test.sv
module serial_rom_reader_test;
  localparam int DIV_W = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [15:0]      req_offset = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic [DIV_W-1:0] div_in = '0;
  logic busy, done, out_valid, out_ready, rom_clk, rom_dout, acc_hi, acc_lo;
  logic rom_din = 1'b0;
  logic [7:0] out_data;

  serial_rom_reader #(.DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .div(div_in), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rom_clk(rom_clk), .rom_dout(rom_dout), .rom_din(rom_din),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_byte(logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
  endfunction

  // EEPROM model, consumer and monitor, all on the falling edge.
  logic pclk = 0, phi = 0, plo = 1, pdout = 0;
  int   rises = 0, nevt = 0, run = 0, min_hold = 1000, ngot = 0, cyc = 0, idx;
  int   rdy_mode = 0, done_w = 0;
  bit   started = 0, dout_bad = 0, clk_bad = 0, stall_bad = 0, pstall = 0, r;
  logic [23:0] hdr = '0;
  logic [1:0]  evt [0:7];
  logic [7:0]  got [0:15];
  logic [7:0]  pdata = '0, bt;

  initial out_ready = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_hi && !phi) begin
        rises = 0; nevt = 0; min_hold = 1000; dout_bad = 0; clk_bad = 0; started = 0;
      end
      if (acc_hi != phi || acc_lo != plo) begin
        if (nevt < 8) evt[nevt] = {acc_hi, acc_lo};
        nevt++;
      end
      if ({acc_hi, acc_lo, rom_clk, rom_dout} != {phi, plo, pclk, pdout}) begin
        if (started && run < min_hold) min_hold = run;
        run = 1; started = 1;
      end else run++;
      if (rom_clk && !pclk) begin
        if (!(acc_hi && !acc_lo)) clk_bad = 1;
        if (rom_dout != pdout) dout_bad = 1;
        if (rises < 24) hdr = {hdr[22:0], rom_dout};
        rises++;
      end
      if (!rom_clk && pclk && rises >= 24) begin
        idx = rises - 24;
        bt = rom_byte(hdr[15:0] + 16'(idx / 8));
        rom_din = bt[7 - (idx % 8)];
      end
      if (pstall && (rom_clk != pclk || !out_valid || out_data != pdata)) stall_bad = 1;
      if (done) done_w++;
      cyc++;
      case (rdy_mode)
        0: r = 1;
        1: r = cyc[0];
        default: r = (cyc % 5 == 0);
      endcase
      out_ready = r;
      if (out_valid && r) begin
        if (ngot < 16) got[ngot] = out_data;
        ngot++;
      end
      pstall = out_valid && !r;
      pdata = out_data;
      pclk = rom_clk; phi = acc_hi; plo = acc_lo; pdout = rom_dout;
    end
  end

  task automatic run_xfer(int d, logic [15:0] off, int cnt, int mode, bit ign);
    int n;
    @(posedge clk); #2;
    div_in = DIV_W'(d); rdy_mode = mode; ngot = 0; stall_bad = 0; done_w = 0;
    chk(!busy, "R8", "busy low before request", busy, 0);
    req_valid = 1; req_offset = off; req_count = CNT_W'(cnt);
    @(posedge clk); #2;
    req_valid = 0;
    chk(busy, "R8", "busy after accept", busy, 1);
    if (ign) begin
      repeat (20) @(posedge clk);
      #2; req_valid = 1; req_offset = ~off; req_count = CNT_W'(2);
      @(posedge clk); #2; req_valid = 0;
    end
    n = 0;
    while (!done && n < 20000) begin @(posedge clk); #2; n++; end
    chk(done == 1, "R8", "done seen", done, 1);
    chk(!busy, "R8", "busy low with done", busy, 0);
    @(posedge clk); #2;
    chk(!done, "R8", "done one cycle", done, 0);
    repeat (3) begin
      @(posedge clk); #2;
      chk(!busy && !acc_hi, "R9", "no transfer after end", {busy, acc_hi}, 0);
    end
    chk(done_w == 1, "R8", "done width", done_w, 1);
    chk(nevt == 4, "R7", "access change count", nevt, 4);
    chk(evt[0] == 2'b11 && evt[1] == 2'b10, "R2", "enable order", {evt[0], evt[1]}, 4'b1110);
    chk(evt[2] == 2'b11 && evt[3] == 2'b01, "R7", "disable order", {evt[2], evt[3]}, 4'b1101);
    chk(!clk_bad, "R2", "clock only while enabled", clk_bad, 0);
    chk(hdr == {8'h03, off}, "R3", "command and address", hdr, {8'h03, off});
    if (ign) chk(hdr[15:0] == off, "R9", "offset kept", hdr[15:0], off);
    chk(!dout_bad, "R3", "dout steady at rise", dout_bad, 0);
    chk(rises == 24 + 8 * cnt, "R5", "clock pulses", rises, 24 + 8 * cnt);
    chk(ngot == cnt, "R5", "byte count", ngot, cnt);
    for (int i = 0; i < cnt && i < 16; i++)
      chk(got[i] == rom_byte(off + 16'(i)), "R4", "byte value", got[i], rom_byte(off + 16'(i)));
    chk(!stall_bad, "R6", "stall freeze", stall_bad, 0);
    chk(min_hold >= d + 1, "R10", "minimum hold", min_hold, d + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    @(posedge clk); #2;
    chk(!acc_hi && acc_lo && !rom_clk, "R1", "reset pins", {acc_hi, acc_lo, rom_clk}, 3'b010);
    chk(!busy && !out_valid && !done, "R1", "reset flags", {busy, out_valid, done}, 0);
    foreach (evt[k]) evt[k] = '0;
    for (int di = 0; di < 4; di++) begin
      for (int c = 0; c < 3; c++) begin
        for (int o = 0; o < 3; o++) begin
          int d, cnt;
          logic [15:0] off;
          d   = (di == 3) ? 5 : di;
          cnt = (c == 2) ? 3 : c;
          off = (o == 0) ? 16'h0000 : (o == 1) ? 16'hFFFF : 16'h5AC3;
          run_xfer(d, off, cnt, (d + cnt + o) % 3, (o == 2 && d >= 1));
        end
      end
    end
    run_xfer(0, 16'h1234, 15, 2, 1'b0);
    run_xfer(1, 16'h8001, 6, 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule